// File: doc/BRIEF.md
# Half-Band Rate Mode Controller

This block sits beside a fixed-coefficient half-band low-pass filter and tells the rest of the datapath what to do on each clock. Two static mode pins pick one of three rate relationships: the input and output sample rates are equal; the output runs at half the input rate (2:1 decimation); or the input runs at half the output rate (1:2 interpolation). In interpolation the filter sees a zero sample on every idle clock.

A phase counter divides the clock by the rate ratio. A marker input realigns it: the marker is sampled high on one clock and low on the next, and that second clock becomes a capture phase. From the mode and the phase the block drives three per-cycle strobes: capture the input word, feed zero to the filter instead of the input word, and load the output register. It also reports the decoded mode and a half-gain flag for the downstream limiter.

A parameter selects one of two decode tables. The two tables differ only in the meaning of both pins low: equal rate in one, unity-gain interpolation in the other.

Top module: `hb_rate_ctrl`

## Requirements
- R1: With VARIANT=0, `mode_code` follows {mode_pin_hi, mode_pin_lo}: 00 gives 2'b00 (equal rate), 01 gives 2'b01 (decimate), 10 gives 2'b10 (interpolate, half gain) and 11 gives 2'b00 (equal rate).
- R2: With VARIANT=1, the decode is the same except that pins 00 give 2'b11 (interpolate, unity gain). That mode strobes exactly like half-gain interpolation.
- R3: In either interpolation mode (code 2'b10 or 2'b11), `out_en` is high on every cycle. `cap_en` is high only on the capture phase (phase 0). `zero_sel` is high only on the idle phase (phase 1).
- R4: In decimate mode (code 2'b01), `cap_en` is high and `zero_sel` is low on every cycle. `out_en` is high only on phase 1, which is every second cycle.
- R5: In equal-rate mode (code 2'b00), `cap_en` and `out_en` are high and `zero_sel` is low on every cycle, whatever `phase_mark` does.
- R6: When `phase_mark` was sampled high on the previous rising edge and is low in the current cycle, the current cycle is phase 0.
- R7: Once aligned, `phase_mark` held low and `phase_mark` toggling every clock with its falls on phase 0 give identical strobes.
- R8: The first cycle after reset release is phase 0. After that the phase advances by one per clock and wraps at RATE-1, unless R6 applies.
- R9: `half_gain` is high only when VARIANT=1 and the mode is half-gain interpolation (code 2'b10). With VARIANT=0 it is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pin_hi | input | 1 | Upper mode select pin |
| mode_pin_lo | input | 1 | Lower mode select pin |
| phase_mark | input | 1 | Phase alignment marker; a high-then-low pair marks a capture phase |
| cap_en | output | 1 | Capture the input word at the end of this cycle |
| zero_sel | output | 1 | Feed a zero sample to the filter this cycle |
| out_en | output | 1 | Load the output register at the end of this cycle |
| mode_code | output | 2 | Decoded rate mode (encoding in R1 and R2) |
| half_gain | output | 1 | Half-gain interpolation flag for the limiter |

## Verification
The bench builds two copies side by side with RATE=2, one with VARIANT=0 and one with VARIANT=1, and drives both from the same pins and marker. With both tables present, the both-pins-low case shows in a single run as equal rate in one copy and unity-gain interpolation in the other, so the only difference between the tables is observed directly. RATE=2 also makes the marker toggling at half the clock rate a legal pattern. The bench places marker falls both on and off the free-running phase, so a realignment shows up as a changed strobe sequence.

// File: rtl/hb_rate_pkg.sv
package hb_rate_pkg;

   typedef enum logic [1:0] {
      MODE_EQUAL     = 2'b00,
      MODE_DECIM     = 2'b01,
      MODE_INT_HALF  = 2'b10,
      MODE_INT_UNITY = 2'b11
   } rate_mode_e;

   localparam int unsigned VARIANT_A = 0;
   localparam int unsigned VARIANT_B = 1;

endpackage

// File: rtl/hb_mode_decode.sv
module hb_mode_decode
   import hb_rate_pkg::*;
#(
   parameter int unsigned VARIANT = VARIANT_A
) (
   input  logic       sel_hi,
   input  logic       sel_lo,
   output rate_mode_e mode,
   output logic       half_gain
);

   generate
      if (VARIANT == VARIANT_B) begin : g_tab_b
         // both pins low selects unity-gain interpolation
         always_comb begin
            case ({sel_hi, sel_lo})
               2'b00:   mode = MODE_INT_UNITY;
               2'b01:   mode = MODE_DECIM;
               2'b10:   mode = MODE_INT_HALF;
               default: mode = MODE_EQUAL;
            endcase
         end
         assign half_gain = (mode == MODE_INT_HALF);
      end else begin : g_tab_a
         // both pin states with equal levels select equal rate
         always_comb begin
            case ({sel_hi, sel_lo})
               2'b01:   mode = MODE_DECIM;
               2'b10:   mode = MODE_INT_HALF;
               default: mode = MODE_EQUAL;
            endcase
         end
         assign half_gain = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hb_phase_track.sv
module hb_phase_track #(
   parameter int unsigned RATE = 2,
   localparam int unsigned PW = (RATE > 2) ? $clog2(RATE) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mark,
   input  logic          armed,
   output logic [PW-1:0] phase
);

   localparam logic [PW-1:0] LAST = PW'(RATE - 1);

   logic          mark_q;
   logic [PW-1:0] ph_q;
   logic [PW-1:0] ph_adv;
   logic          mark_fall;

   assign mark_fall = mark_q & ~mark;
   assign ph_adv    = (ph_q == LAST) ? '0 : ph_q + 1'b1;
   assign phase     = mark_fall ? '0 : ph_adv;

   // reset to the last phase so the first live cycle lands on phase 0
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark_q <= 1'b0;
         ph_q   <= LAST;
      end else begin
         mark_q <= mark;
         ph_q   <= phase;
      end
   end

   assert_phase_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST);

   assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !($past(mark) && !mark)) |->
         (phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1)));

endmodule

// File: rtl/hb_strobe_gen.sv
module hb_strobe_gen
   import hb_rate_pkg::*;
#(
   parameter int unsigned RATE = 2,
   localparam int unsigned PW = (RATE > 2) ? $clog2(RATE) : 1
) (
   input  rate_mode_e    mode,
   input  logic [PW-1:0] phase,
   output logic          cap_en,
   output logic          zero_sel,
   output logic          out_en
);

   localparam logic [PW-1:0] CAP_PH = '0;
   localparam logic [PW-1:0] OUT_PH = PW'(RATE - 1);

   always_comb begin
      cap_en   = 1'b1;
      zero_sel = 1'b0;
      out_en   = 1'b1;
      case (mode)
         MODE_DECIM: begin
            out_en = (phase == OUT_PH);
         end
         MODE_INT_HALF, MODE_INT_UNITY: begin
            cap_en   = (phase == CAP_PH);
            zero_sel = (phase != CAP_PH);
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/hb_rate_ctrl.sv
module hb_rate_ctrl
   import hb_rate_pkg::*;
#(
   parameter int unsigned VARIANT = VARIANT_A,
   parameter int unsigned RATE    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_pin_hi,
   input  logic       mode_pin_lo,
   input  logic       phase_mark,
   output logic       cap_en,
   output logic       zero_sel,
   output logic       out_en,
   output logic [1:0] mode_code,
   output logic       half_gain
);

   localparam int unsigned PW = (RATE > 2) ? $clog2(RATE) : 1;

   initial begin
      chk_variant: assert (VARIANT == VARIANT_A || VARIANT == VARIANT_B)
         else $error("hb_rate_ctrl: VARIANT must be 0 or 1");
      chk_rate: assert (RATE >= 2 && RATE <= 16)
         else $error("hb_rate_ctrl: RATE must lie in 2..16");
   end

   rate_mode_e    mode;
   logic [PW-1:0] phase;
   logic          armed_q;

   // set after the first clock out of reset; qualifies $past in checks
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   hb_mode_decode #(.VARIANT(VARIANT)) u_decode (
      .sel_hi    (mode_pin_hi),
      .sel_lo    (mode_pin_lo),
      .mode      (mode),
      .half_gain (half_gain)
   );

   hb_phase_track #(.RATE(RATE)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .mark  (phase_mark),
      .armed (armed_q),
      .phase (phase)
   );

   hb_strobe_gen #(.RATE(RATE)) u_strobe (
      .mode     (mode),
      .phase    (phase),
      .cap_en   (cap_en),
      .zero_sel (zero_sel),
      .out_en   (out_en)
   );

   assign mode_code = mode;

   assert_equal_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 2'b00) |-> (cap_en && out_en && !zero_sel));

   assert_decim_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 2'b01) |-> (cap_en && !zero_sel));

   assert_interp_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code[1]) |-> ((cap_en ^ zero_sel) && out_en));

   assert_mark_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && mode_code[1] && $past(phase_mark) && !phase_mark) |-> cap_en);

   assert_gain_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      half_gain |-> (mode_code == 2'b10 && VARIANT == VARIANT_B));

   assert_unity_gain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 2'b11) |-> !half_gain);

   generate
      if (RATE == 2) begin : g_half_checks
         assert_decim_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && mode_code == 2'b01 && $past(mode_code) == 2'b01 &&
             !($past(phase_mark) && !phase_mark)) |-> (out_en != $past(out_en)));

         assert_interp_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && mode_code[1] && $past(mode_code[1]) &&
             !($past(phase_mark) && !phase_mark)) |-> (cap_en != $past(cap_en)));
      end
   endgenerate

endmodule

// File: tb/hb_rate_ctrl_test.sv
module hb_rate_ctrl_test;

   localparam int CLK_P = 10;

   typedef struct packed {
      logic [1:0] ca;
      logic [1:0] cb;
      logic [2:0] sa;
      logic [2:0] sb;
      logic       hga;
      logic       hgb;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_hi = 1'b0;
   logic pin_lo = 1'b0;
   logic mark = 1'b0;

   logic       cap_a, zero_a, out_a, hg_a;
   logic       cap_b, zero_b, out_b, hg_b;
   logic [1:0] code_a, code_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   exp_t  q_exp[$];
   string q_tag[$];

   int b_ph = 0;
   bit b_ps = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   hb_rate_ctrl #(.VARIANT(0), .RATE(2)) uut_a (
      .clk(clk), .rst_n(rst_n), .mode_pin_hi(pin_hi), .mode_pin_lo(pin_lo),
      .phase_mark(mark), .cap_en(cap_a), .zero_sel(zero_a), .out_en(out_a),
      .mode_code(code_a), .half_gain(hg_a));

   hb_rate_ctrl #(.VARIANT(1), .RATE(2)) uut (
      .clk(clk), .rst_n(rst_n), .mode_pin_hi(pin_hi), .mode_pin_lo(pin_lo),
      .phase_mark(mark), .cap_en(cap_b), .zero_sel(zero_b), .out_en(out_b),
      .mode_code(code_b), .half_gain(hg_b));

   // R1 and R2 decode tables
   function automatic logic [1:0] code_of(bit varb, bit hi, bit lo);
      case ({hi, lo})
         2'b00:   return varb ? 2'b11 : 2'b00;
         2'b01:   return 2'b01;
         2'b10:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   // {cap, zero, out} from R3, R4, R5
   function automatic logic [2:0] strobes_of(logic [1:0] code, int ph);
      case (code)
         2'b00:   return 3'b101;
         2'b01:   return {1'b1, 1'b0, (ph == 1)};
         default: return {(ph == 0), (ph == 1), 1'b1};
      endcase
   endfunction

   task automatic push_exp(int ph, string tag);
      exp_t e;
      e.ca  = code_of(1'b0, pin_hi, pin_lo);
      e.cb  = code_of(1'b1, pin_hi, pin_lo);
      e.sa  = strobes_of(e.ca, ph);
      e.sb  = strobes_of(e.cb, ph);
      e.hga = 1'b0;
      e.hgb = (e.cb == 2'b10);
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic step(bit hi, bit lo, bit mk, string tag);
      int ph;
      @(posedge clk);
      #1;
      pin_hi = hi; pin_lo = lo; mark = mk;
      ph = (b_ps && !mk) ? 0 : (b_ph + 1) % 2;   // R6 realign, else advance
      push_exp(ph, tag);
      b_ph = ph;
      b_ps = mk;
   endtask

   task automatic do_reset(bit hi, bit lo, bit mk);
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      pin_hi = hi; pin_lo = lo; mark = mk;
      push_exp(0, "R8");               // first live cycle is phase 0
      b_ph = 0;
      b_ps = mk;
   endtask

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // monitor: pop and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk(t,    "cap_a",  cap_a,  e.sa[2]);
            chk(t,    "zero_a", zero_a, e.sa[1]);
            chk(t,    "out_a",  out_a,  e.sa[0]);
            chk(t,    "cap_b",  cap_b,  e.sb[2]);
            chk(t,    "zero_b", zero_b, e.sb[1]);
            chk(t,    "out_b",  out_b,  e.sb[0]);
            chk("R1", "code_a", code_a, e.ca);
            chk("R2", "code_b", code_b, e.cb);
            chk("R9", "hg_a",   hg_a,   e.hga);
            chk("R9", "hg_b",   hg_b,   e.hgb);
         end
      end
   end

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R8: reset into half-gain interpolation
      do_reset(1'b1, 1'b0, 1'b0);
      // R3: free-running alternation
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R3");
      // R6: marker fall on a would-be idle phase forces a capture phase
      step(1'b1, 1'b0, 1'b1, "R6");
      step(1'b1, 1'b0, 1'b0, "R6");
      // R7: toggling marker, falls aligned to phase 0
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, (i % 2 == 0), "R7");
      // R4: decimation
      for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b0, 1'b1, 1'b1, "R6");
      step(1'b0, 1'b1, 1'b0, "R6");
      step(1'b0, 1'b1, 1'b0, "R4");
      // R2: pins 00, equal in one table, unity interpolation in the other
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0, (i == 2 || i == 3 || i == 5), "R2");
      // R5: equal rate with marker activity
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, (i % 3 == 0), "R5");
      // R8: second reset, in decimation with marker high on release
      do_reset(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b1, 1'b0, "R6");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b1, 1'b0, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b0, "R3");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule